// File: doc/BRIEF.md
# Single-Entry Committed Store Holding Buffer

This block sits between the end of a store pipe and the memory interface. A store that has finished executing is parked here together with its address, data and access width. Memory is not touched while the store is still speculative. When the commit stage retires the store, the entry changes to a draining state and raises a memory request. It keeps that request up for as many cycles as memory needs to acknowledge it, so a cache miss on the write does not hold back the commit of younger instructions. A flush that arrives before commit throws the parked store away.

Loads look in this buffer before they go to the cache. The store is visible to loads from the cycle after it is captured until the cycle its memory write is acknowledged. A word store can feed any load that falls inside its word. A byte store can feed a byte load at the same address. A word load that overlaps a byte store is told to stall until the drain completes, because partial data is never merged.

Top module: `store_hold_buf`

## Requirements
- R1: During and right after reset the entry is empty: `st_ready_o`=1, `mem_req_o`=0, and `ld_hit_o`=`ld_stall_o`=0 for any load.
- R2: There is only one entry. A store is taken on a clock edge where `st_valid_i` and `st_ready_o` are both 1. `st_ready_o` stays 0 from then until the entry is freed, and stores offered in that time are ignored: the parked address and data do not change.
- R3: `mem_req_o` stays 0 while the parked store is uncommitted. A `commit_i` pulse sampled while the store is parked and uncommitted raises `mem_req_o` from the next cycle.
- R4: While `mem_req_o`=1 and `mem_ack_i`=0, the request and `mem_addr_o`, `mem_data_o` and `mem_word_o` hold steady for any number of cycles. An edge with `mem_ack_i`=1 frees the entry, so `st_ready_o`=1 and `mem_req_o`=0 in the next cycle.
- R5: `flush_i` sampled while the store is parked and uncommitted discards it: `st_ready_o`=1 next cycle and no request is ever made. If `commit_i` and `flush_i` arrive together, the commit wins.
- R6: `flush_i` and `commit_i` have no effect on an empty entry or on a draining entry. A draining store still completes its request.
- R7: Access width is encoded 1=word (4 bytes), 0=byte. A word load whose word address (address bits above bit 1) matches a parked word store gets `ld_hit_o`=1 and the full stored word on `ld_data_o`.
- R8: A byte load inside the word of a parked word store gets `ld_hit_o`=1. `ld_data_o` carries byte lane `addr[1:0]`, zero-extended. Lane k is data bits 8k+7..8k (little-endian).
- R9: A byte load at exactly the address of a parked byte store hits and returns that byte, zero-extended. Any other non-overlapping load gets `ld_hit_o`=0, `ld_stall_o`=0 and `ld_data_o`=0.
- R10: A word load whose word contains a parked byte store gets `ld_stall_o`=1 and `ld_hit_o`=0. Hit and stall are never 1 together.
- R11: During a drain, a word store presents its address with bits 1..0 cleared and its full data. A byte store presents its exact address and data bits 7..0 with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Executed store offered |
| st_ready_o | output | 1 | Entry free, store can be taken |
| st_addr_i | input | AW | Store byte address |
| st_data_i | input | DW | Store data |
| st_word_i | input | 1 | Store width, 1=word 0=byte |
| commit_i | input | 1 | Parked store is retired |
| flush_i | input | 1 | Discard uncommitted store |
| ld_valid_i | input | 1 | Load lookup valid |
| ld_addr_i | input | AW | Load byte address |
| ld_word_i | input | 1 | Load width, 1=word 0=byte |
| ld_hit_o | output | 1 | Load served from buffer |
| ld_stall_o | output | 1 | Load must wait for drain |
| ld_data_o | output | DW | Forwarded load data |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | AW | Memory write address |
| mem_data_o | output | DW | Memory write data |
| mem_word_o | output | 1 | Memory write width |
| mem_ack_i | input | 1 | Memory write done |

## Verification
The hardest case to reach is a draining store whose acknowledge is held back while, in the same cycles, flushes, commits, new stores and overlapping loads keep arriving. To get there, the stimulus holds `mem_ack_i` low for long directed stretches. The random phase drives the acknowledge at low probability. Store and load addresses are drawn from two adjacent words, so byte and word overlaps, stalls and misses come up often during both the parked and the draining phases.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  typedef enum logic [1:0] {
    SB_EMPTY = 2'd0,
    SB_HELD  = 2'd1,
    SB_DRAIN = 2'd2
  } sb_state_e;
endpackage

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
  import sbuf_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      st_valid_i,
  input  logic      commit_i,
  input  logic      flush_i,
  input  logic      mem_ack_i,
  output logic      capture_o,
  output sb_state_e state_o
);
  sb_state_e state_q, state_d;

  assign capture_o = st_valid_i && (state_q == SB_EMPTY);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SB_EMPTY: if (st_valid_i) state_d = SB_HELD;
      SB_HELD: begin
        // commit outranks flush: the store is older than the flushed work
        if (commit_i)     state_d = SB_DRAIN;
        else if (flush_i) state_d = SB_EMPTY;
      end
      SB_DRAIN: if (mem_ack_i) state_d = SB_EMPTY;
      default:  state_d = SB_EMPTY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SB_EMPTY;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_FLUSH_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SB_HELD && flush_i && !commit_i) |=> state_q == SB_EMPTY); // R5
  AST_DRAIN_SURVIVES_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SB_DRAIN && !mem_ack_i) |=> state_q == SB_DRAIN); // R6
endmodule

// File: rtl/sbuf_entry.sv
module sbuf_entry #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic          st_word_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          word_o
);
  localparam int LB = $clog2(DW / 8);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      word_q <= 1'b0;
    end else if (cap_i) begin
      addr_q <= st_word_i ? {st_addr_i[AW-1:LB], {LB{1'b0}}} : st_addr_i;
      data_q <= st_word_i ? st_data_i : {{(DW-8){1'b0}}, st_data_i[7:0]};
      word_q <= st_word_i;
    end
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
  assign word_o = word_q;
endmodule

// File: rtl/sbuf_fwd.sv
module sbuf_fwd #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          e_valid_i,
  input  logic [AW-1:0] e_addr_i,
  input  logic [DW-1:0] e_data_i,
  input  logic          e_word_i,
  input  logic          ld_valid_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic          ld_word_i,
  output logic          hit_o,
  output logic          stall_o,
  output logic [DW-1:0] data_o
);
  localparam int LANES = DW / 8;
  localparam int LB    = $clog2(LANES);

  logic [7:0] lane [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = e_data_i[8*g +: 8];
  end

  logic same_word, same_byte;
  assign same_word = ld_addr_i[AW-1:LB] == e_addr_i[AW-1:LB];
  assign same_byte = ld_addr_i[LB-1:0] == e_addr_i[LB-1:0];

  always_comb begin
    hit_o   = 1'b0;
    stall_o = 1'b0;
    data_o  = '0;
    if (e_valid_i && ld_valid_i && same_word) begin
      if (e_word_i) begin
        hit_o  = 1'b1;
        data_o = ld_word_i ? e_data_i : {{(DW-8){1'b0}}, lane[ld_addr_i[LB-1:0]]};
      end else if (ld_word_i) begin
        stall_o = 1'b1;  // no partial merge
      end else if (same_byte) begin
        hit_o  = 1'b1;
        data_o = {{(DW-8){1'b0}}, e_data_i[7:0]};
      end
    end
  end
endmodule

// File: rtl/store_hold_buf.sv
module store_hold_buf
  import sbuf_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  output logic          st_ready_o,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic          st_word_i,
  input  logic          commit_i,
  input  logic          flush_i,
  input  logic          ld_valid_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic          ld_word_i,
  output logic          ld_hit_o,
  output logic          ld_stall_o,
  output logic [DW-1:0] ld_data_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  output logic          mem_word_o,
  input  logic          mem_ack_i
);
  sb_state_e     state;
  logic          cap;
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_data;
  logic          e_word;

  sbuf_ctrl u_ctrl (
    .clk_i, .rst_ni, .st_valid_i, .commit_i, .flush_i, .mem_ack_i,
    .capture_o(cap), .state_o(state)
  );

  sbuf_entry #(.AW(AW), .DW(DW)) u_entry (
    .clk_i, .rst_ni, .cap_i(cap), .st_addr_i, .st_data_i, .st_word_i,
    .addr_o(e_addr), .data_o(e_data), .word_o(e_word)
  );

  sbuf_fwd #(.AW(AW), .DW(DW)) u_fwd (
    .e_valid_i(state != SB_EMPTY), .e_addr_i(e_addr), .e_data_i(e_data),
    .e_word_i(e_word), .ld_valid_i, .ld_addr_i, .ld_word_i,
    .hit_o(ld_hit_o), .stall_o(ld_stall_o), .data_o(ld_data_o)
  );

  assign st_ready_o = state == SB_EMPTY;
  assign mem_req_o  = state == SB_DRAIN;
  assign mem_addr_o = e_addr;
  assign mem_data_o = e_data;
  assign mem_word_o = e_word;

  AST_SINGLE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_ready_o |-> !mem_req_o && !ld_hit_o && !ld_stall_o); // R2
  AST_NO_SPEC_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(commit_i)); // R3
  AST_REQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_data_o) && $stable(mem_word_o)); // R4
  AST_FREE_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> st_ready_o); // R4
  AST_HIT_XOR_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_hit_o && ld_stall_o)); // R10
endmodule

// File: tb/tb_store_hold_buf.sv
`timescale 1ns/1ps
module tb_store_hold_buf;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          st_valid, st_ready, st_word, commit, flush;
  logic [AW-1:0] st_addr, ld_addr, mem_addr;
  logic [DW-1:0] st_data, ld_data, mem_data;
  logic          ld_valid, ld_word, ld_hit, ld_stall;
  logic          mem_req, mem_word, mem_ack;

  store_hold_buf #(.AW(AW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_ready_o(st_ready), .st_addr_i(st_addr),
    .st_data_i(st_data), .st_word_i(st_word),
    .commit_i(commit), .flush_i(flush),
    .ld_valid_i(ld_valid), .ld_addr_i(ld_addr), .ld_word_i(ld_word),
    .ld_hit_o(ld_hit), .ld_stall_o(ld_stall), .ld_data_o(ld_data),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .mem_word_o(mem_word), .mem_ack_i(mem_ack)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // model: 0 empty, 1 parked, 2 draining
  int            m_st = 0;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;
  logic          m_word;

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] exp_maddr();
    return m_word ? {m_addr[AW-1:2], 2'b00} : m_addr;
  endfunction

  function automatic logic [DW-1:0] exp_mdata();
    return m_word ? m_data : {24'b0, m_data[7:0]};
  endfunction

  // expected lookup result; returns requirement tag
  function automatic string exp_ld(output logic h, output logic s, output logic [DW-1:0] d);
    h = 0; s = 0; d = '0;
    if (m_st == 0 || !ld_valid) return "R1";
    if (ld_addr[AW-1:2] != m_addr[AW-1:2]) return "R9";
    if (m_word) begin
      h = 1;
      if (ld_word) begin d = m_data; return "R7"; end
      d = {24'b0, m_data[8*ld_addr[1:0] +: 8]};
      return "R8";
    end
    if (ld_word) begin s = 1; return "R10"; end
    if (ld_addr == m_addr) begin h = 1; d = {24'b0, m_data[7:0]}; end
    return "R9";
  endfunction

  task automatic step(input logic sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                      input logic sw, input logic cm, input logic fl, input logic ak,
                      input logic lv, input logic [AW-1:0] la, input logic lw,
                      input string tg);
    logic h, s;
    logic [DW-1:0] d;
    string lt;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd; st_word = sw;
    commit = cm; flush = fl; mem_ack = ak;
    ld_valid = lv; ld_addr = la; ld_word = lw;
    #1;
    chk(st_ready == (m_st == 0), {"R2 ", tg}, "st_ready", 32'(st_ready), 32'(m_st == 0));
    chk(mem_req == (m_st == 2), {"R3 ", tg}, "mem_req", 32'(mem_req), 32'(m_st == 2));
    if (m_st == 2) begin
      chk(mem_addr == exp_maddr(), {"R11 ", tg}, "mem_addr", 32'(mem_addr), 32'(exp_maddr()));
      chk(mem_data == exp_mdata(), {"R11 ", tg}, "mem_data", mem_data, exp_mdata());
      chk(mem_word == m_word, {"R11 ", tg}, "mem_word", 32'(mem_word), 32'(m_word));
    end
    lt = exp_ld(h, s, d);
    chk(ld_hit == h, {lt, " ", tg}, "ld_hit", 32'(ld_hit), 32'(h));
    chk(ld_stall == s, {lt, " ", tg}, "ld_stall", 32'(ld_stall), 32'(s));
    chk(ld_data == d, {lt, " ", tg}, "ld_data", ld_data, d);
    @(posedge clk);
    case (m_st)
      0: if (sv) begin m_st = 1; m_addr = sa; m_data = sd; m_word = sw; end
      1: if (cm) m_st = 2; else if (fl) m_st = 0;
      default: if (ak) m_st = 0;
    endcase
  endtask

  task automatic idle(input string tg);
    step(0, '0, '0, 0, 0, 0, 0, 0, '0, 0, tg);
  endtask

  task automatic look(input logic [AW-1:0] la, input logic lw, input string tg);
    step(0, '0, '0, 0, 0, 0, 0, 1, la, lw, tg);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    st_valid = 0; st_addr = '0; st_data = '0; st_word = 0;
    commit = 0; flush = 0; mem_ack = 0;
    ld_valid = 1; ld_addr = '0; ld_word = 1;
    #11;
    chk(st_ready === 1'b1, "R1", "reset st_ready", 32'(st_ready), 1);
    chk(mem_req === 1'b0, "R1", "reset mem_req", 32'(mem_req), 0);
    chk(ld_hit === 1'b0 && ld_stall === 1'b0, "R1", "reset lookup", 32'({ld_hit, ld_stall}), 0);
    @(negedge clk);
    rst_n = 1;
    idle("R1");

    // word store, forward word and bytes, refuse second store
    step(1, 16'h0102, 32'hA1B2C3D4, 1, 0, 0, 0, 0, '0, 0, "R2");
    look(16'h0100, 1, "R7");
    look(16'h0103, 0, "R8");
    look(16'h0101, 0, "R8");
    look(16'h0104, 1, "R9");
    step(1, 16'h0200, 32'h11111111, 1, 0, 0, 0, 1, 16'h0102, 1, "R2");
    look(16'h0100, 1, "R2");
    // commit; hold ack off, flush during drain ignored
    step(0, '0, '0, 0, 1, 0, 0, 0, '0, 0, "R3");
    step(0, '0, '0, 0, 0, 1, 0, 1, 16'h0100, 1, "R6");
    for (int i = 0; i < 5; i++) idle("R4");
    step(0, '0, '0, 0, 1, 1, 1, 0, '0, 0, "R4");
    idle("R4");

    // byte store: stall word load, flush before commit
    step(1, 16'h0105, 32'hFFEEDD5A, 0, 0, 0, 1, 0, '0, 0, "R6");
    look(16'h0104, 1, "R10");
    look(16'h0105, 0, "R9");
    look(16'h0106, 0, "R9");
    step(0, '0, '0, 0, 0, 1, 0, 1, 16'h0105, 0, "R5");
    for (int i = 0; i < 3; i++) idle("R5");

    // commit and flush together: commit wins, byte drain shape
    step(1, 16'h0107, 32'h12345678, 0, 0, 0, 0, 0, '0, 0, "R11");
    step(0, '0, '0, 0, 1, 1, 0, 0, '0, 0, "R5");
    for (int i = 0; i < 3; i++) idle("R11");
    step(0, '0, '0, 0, 0, 0, 1, 0, '0, 0, "R4");
    idle("R4");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] sa, la;
      sa = 16'h0100 + 16'($urandom_range(0, 7));
      la = 16'h0100 + 16'($urandom_range(0, 7));
      step($urandom_range(0, 3) == 0, sa, $urandom, 1'($urandom), $urandom_range(0, 3) == 0,
           $urandom_range(0, 5) == 0, $urandom_range(0, 4) == 0,
           1'($urandom), la, 1'($urandom), "RND");
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule